// File: doc/BRIEF.md
# Byte-Wide Bidirectional Parallel Port (Host Side)

This block is the host end of a byte-wide parallel link. A CPU reaches three 8-bit registers through a small synchronous register interface: a data register at offset 0, a status register at offset 1 and a control register at offset 2. On the pin side it has an 8-bit data bus, four status inputs from the peripheral and four control outputs. The data bus is split into an output byte, an output-enable and an input byte, so that a tri-state pad can be placed outside the block.

In the default bidirectional variant, control bit 5 selects the bus direction. When the bit is clear, the port drives its output latch onto the bus and a data read returns that latch. When the bit is set, the port releases the bus and a data read returns the byte the peripheral is driving. A legacy variant (parameter `LEGACY=1`) models an output-only port. It always drives the bus, ignores bit 5, and returns the bitwise AND of the latch and the peripheral byte on a data read, so software that depends on the direction bit can be tested against both behaviours.

The direction is held by a two-state machine. `DIR_DRIVE` is the reset state. A control write with bit 5 set moves it to `DIR_LISTEN` (transition *release*), but only in the bidirectional variant. A control write with bit 5 clear moves it back to `DIR_DRIVE` (transition *reclaim*). Any other cycle holds the current state.

Top module: `ppio_port`

## Requirements
- R1: Only offsets 0 (data), 1 (status) and 2 (control) are decoded. A write to any other offset changes neither register nor any pin, and a read of any other offset returns 0x00.
- R2: In the bidirectional variant, control bit 5 = 0 sets `pd_oe`=1 with `pd_out` equal to the data latch. Control bit 5 = 1 sets `pd_oe`=0, and a data read then returns the synchronized peripheral byte.
- R3: In the bidirectional variant with control bit 5 = 0, a data read returns the output latch, whatever the peripheral is driving.
- R4: In the legacy variant, `pd_oe` is always 1 and a data read returns the latch ANDed with the synchronized peripheral byte, whatever the value of control bit 5.
- R5: Status read layout: bit 7 is the inverse of the `pin_busy` level, bit 6 is `pin_ack`, bit 4 is `pin_select` and bit 3 is `pin_error`. Bits 5, 2, 1 and 0 read 0.
- R6: Control bits drive pins at the written level: bit 0 drives `pin_strobe`, bit 1 drives `pin_autofeed`, bit 2 drives `pin_init` and bit 3 drives `pin_select_in`. The whole byte reads back as written, and bits 4, 6 and 7 affect no pin.
- R7: Status pins and peripheral data pass through a two-flop synchronizer. A pin change is not readable after one rising edge and is readable after the second.
- R8: After reset the control register and the data latch are 0x00, `pd_oe`=1, and all four control outputs are 0.
- R9: A register write takes effect at the rising edge on which `cpu_wr` is sampled high. `pd_out`, `pd_oe` and the control pins reflect it right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | ADDR_W | Register offset |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` (combinational) |
| pd_in | input | 8 | Byte sensed on the data pins |
| pd_out | output | 8 | Byte driven onto the data pins |
| pd_oe | output | 1 | Data pin output enable |
| pin_busy | input | 1 | Peripheral busy level |
| pin_ack | input | 1 | Peripheral acknowledge |
| pin_select | input | 1 | Peripheral online |
| pin_error | input | 1 | Peripheral error |
| pin_strobe | output | 1 | Data strobe |
| pin_autofeed | output | 1 | Auto-feed / handshake line |
| pin_init | output | 1 | Initialize line |
| pin_select_in | output | 1 | Select-in line |

## Verification
The assertions assume that `cpu_wr` is a single-cycle pulse with a stable address and data while it is high. They also assume that the pin inputs are arbitrary and may change on any cycle. The stimulus makes every write last exactly one cycle and drives all inputs on the falling edge. Pins change only while the CPU side is idle or reading, so each read sees a settled synchronizer. The legacy properties apply only to the instance built with `LEGACY=1`, which shares the bench stimulus with the bidirectional instance.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    typedef enum logic [0:0] {
        DIR_DRIVE  = 1'b0,
        DIR_LISTEN = 1'b1
    } dir_state_e;

    localparam int OFS_DATA = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_CTRL = 2;

    localparam int CTL_STROBE   = 0;
    localparam int CTL_AUTOFEED = 1;
    localparam int CTL_INIT     = 2;
    localparam int CTL_SELIN    = 3;
    localparam int CTL_DIR      = 5;

    localparam int STS_ERROR  = 3;
    localparam int STS_SELECT = 4;
    localparam int STS_ACK    = 6;
    localparam int STS_BUSY   = 7;

    localparam int REG_W     = 8;
    localparam int STS_PINS  = 4;

endpackage

// File: rtl/ppio_sync.sv
module ppio_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/ppio_regs.sv
module ppio_regs
    import ppio_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  data_q,
    output logic [REG_W-1:0]  ctrl_q,
    output logic              ctrl_wr,
    output logic              ctrl_dir
);

    logic hit_data;
    logic hit_ctrl;

    always_comb begin
        hit_data = (cpu_addr == ADDR_W'(OFS_DATA));
        hit_ctrl = (cpu_addr == ADDR_W'(OFS_CTRL));
    end

    assign ctrl_wr  = cpu_wr && hit_ctrl;
    assign ctrl_dir = cpu_wdata[CTL_DIR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (cpu_wr && hit_data) begin
            data_q <= cpu_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= cpu_wdata;
        end
    end

endmodule

// File: rtl/ppio_dir_fsm.sv
module ppio_dir_fsm
    import ppio_pkg::*;
#(
    parameter bit LEGACY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_dir,
    output logic drive_en,
    output logic listening
);

    dir_state_e state_q;
    dir_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIR_DRIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIR_DRIVE: begin
                if (ctrl_wr && ctrl_dir && !LEGACY) begin
                    state_d = DIR_LISTEN;
                end
            end
            DIR_LISTEN: begin
                if (ctrl_wr && !ctrl_dir) begin
                    state_d = DIR_DRIVE;
                end
            end
            default: state_d = DIR_DRIVE;
        endcase
    end

    always_comb begin
        drive_en  = 1'b1;
        listening = 1'b0;
        unique case (state_q)
            DIR_DRIVE: begin
                drive_en  = 1'b1;
                listening = 1'b0;
            end
            DIR_LISTEN: begin
                drive_en  = 1'b0;
                listening = 1'b1;
            end
            default: begin
                drive_en  = 1'b1;
                listening = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ppio_port.sv
module ppio_port
    import ppio_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter bit LEGACY      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic [7:0]        pd_in,
    output logic [7:0]        pd_out,
    output logic              pd_oe,
    input  logic              pin_busy,
    input  logic              pin_ack,
    input  logic              pin_select,
    input  logic              pin_error,
    output logic              pin_strobe,
    output logic              pin_autofeed,
    output logic              pin_init,
    output logic              pin_select_in
);

    localparam int SYNC_W = REG_W + STS_PINS;

    logic [REG_W-1:0]  data_q;
    logic [REG_W-1:0]  ctrl_q;
    logic              ctrl_wr;
    logic              ctrl_dir;
    logic              drive_en;
    logic              listening;
    logic [SYNC_W-1:0] sync_out;
    logic [REG_W-1:0]  per_byte;
    logic              busy_s, ack_s, sel_s, err_s;
    logic [REG_W-1:0]  status_word;
    logic [REG_W-1:0]  data_read;

    ppio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .cpu_wdata(cpu_wdata),
        .data_q   (data_q),
        .ctrl_q   (ctrl_q),
        .ctrl_wr  (ctrl_wr),
        .ctrl_dir (ctrl_dir)
    );

    ppio_dir_fsm #(.LEGACY(LEGACY)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .ctrl_dir (ctrl_dir),
        .drive_en (drive_en),
        .listening(listening)
    );

    ppio_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({pin_busy, pin_ack, pin_select, pin_error, pd_in}),
        .sync_out(sync_out)
    );

    assign per_byte = sync_out[REG_W-1:0];
    assign {busy_s, ack_s, sel_s, err_s} = sync_out[SYNC_W-1:REG_W];

    always_comb begin
        status_word             = '0;
        status_word[STS_BUSY]   = ~busy_s;
        status_word[STS_ACK]    = ack_s;
        status_word[STS_SELECT] = sel_s;
        status_word[STS_ERROR]  = err_s;
    end

    generate
        if (LEGACY) begin : g_legacy_read
            assign data_read = data_q & per_byte;
        end else begin : g_bidir_read
            assign data_read = listening ? per_byte : data_q;
        end
    endgenerate

    always_comb begin
        if (cpu_addr == ADDR_W'(OFS_DATA)) begin
            cpu_rdata = data_read;
        end else if (cpu_addr == ADDR_W'(OFS_STAT)) begin
            cpu_rdata = status_word;
        end else if (cpu_addr == ADDR_W'(OFS_CTRL)) begin
            cpu_rdata = ctrl_q;
        end else begin
            cpu_rdata = '0;
        end
    end

    assign pd_out        = data_q;
    assign pd_oe         = drive_en;
    assign pin_strobe    = ctrl_q[CTL_STROBE];
    assign pin_autofeed  = ctrl_q[CTL_AUTOFEED];
    assign pin_init      = ctrl_q[CTL_INIT];
    assign pin_select_in = ctrl_q[CTL_SELIN];

endmodule

// File: rtl/ppio_port_chk.sv
module ppio_port_chk #(
    parameter int ADDR_W = 3,
    parameter bit LEGACY = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic [7:0]        cpu_wdata,
    input logic [7:0]        cpu_rdata,
    input logic [7:0]        pd_out,
    input logic              pd_oe,
    input logic              pin_strobe,
    input logic              pin_autofeed,
    input logic              pin_init,
    input logic              pin_select_in
);

    logic [3:0] ctl_pins;
    logic       hi_ofs;
    assign ctl_pins = {pin_select_in, pin_init, pin_autofeed, pin_strobe};
    assign hi_ofs   = (cpu_addr > ADDR_W'(2));

    // R1: writes above offset 2 touch nothing visible
    assert_ignore_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && hi_ofs) |=> ($stable(pd_out) && $stable(ctl_pins) && $stable(pd_oe)));

    // R1: reads above offset 2 return zero
    assert_read_high_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hi_ofs |-> (cpu_rdata == 8'h00));

    // R2: direction bit set releases the bus (bidirectional only)
    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!LEGACY && cpu_wr && cpu_addr == ADDR_W'(2) && cpu_wdata[5]) |=> !pd_oe);

    // R2: direction bit clear reclaims the bus
    assert_reclaim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == ADDR_W'(2) && !cpu_wdata[5]) |=> pd_oe);

    // R4: legacy variant never releases the bus
    assert_legacy_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        LEGACY |-> pd_oe);

    // R5: unused status bits read zero
    assert_status_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == ADDR_W'(1)) |-> (cpu_rdata[5] == 1'b0 && cpu_rdata[2:0] == 3'b000));

    // R9: control pins change only after a control write
    assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == ADDR_W'(2)) |=> $stable(ctl_pins));

    // R9: driven byte changes only after a data write
    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == ADDR_W'(0)) |=> $stable(pd_out));

    // R6: control pins follow the written low nibble
    assert_ctl_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == ADDR_W'(2)) |=> (ctl_pins == $past(cpu_wdata[3:0])));

endmodule

bind ppio_port ppio_port_chk #(.ADDR_W(ADDR_W), .LEGACY(LEGACY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_wr       (cpu_wr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .pd_out       (pd_out),
    .pd_oe        (pd_oe),
    .pin_strobe   (pin_strobe),
    .pin_autofeed (pin_autofeed),
    .pin_init     (pin_init),
    .pin_select_in(pin_select_in)
);

// File: tb/tb_ppio_port.sv
`timescale 1ns/1ps
module tb_ppio_port;

    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_wr = 1'b0;
    logic [7:0]        cpu_wdata = '0;
    logic [7:0]        pd_in = '0;
    logic              pin_busy = 1'b0, pin_ack = 1'b0, pin_select = 1'b0, pin_error = 1'b0;

    logic [7:0] rd_b, rd_l, out_b, out_l;
    logic       oe_b, oe_l;
    logic       stb_b, afd_b, ini_b, sli_b;
    logic       stb_l, afd_l, ini_l, sli_l;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ppio_port #(.ADDR_W(ADDR_W), .LEGACY(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(rd_b), .pd_in(pd_in), .pd_out(out_b),
        .pd_oe(oe_b), .pin_busy(pin_busy), .pin_ack(pin_ack),
        .pin_select(pin_select), .pin_error(pin_error), .pin_strobe(stb_b),
        .pin_autofeed(afd_b), .pin_init(ini_b), .pin_select_in(sli_b)
    );

    ppio_port #(.ADDR_W(ADDR_W), .LEGACY(1'b1)) dut_leg (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(rd_l), .pd_in(pd_in), .pd_out(out_l),
        .pd_oe(oe_l), .pin_busy(pin_busy), .pin_ack(pin_ack),
        .pin_select(pin_select), .pin_error(pin_error), .pin_strobe(stb_l),
        .pin_autofeed(afd_l), .pin_init(ini_l), .pin_select_in(sli_l)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic wr(input int ofs, input logic [7:0] val);
        @(negedge clk);
        cpu_addr  = ADDR_W'(ofs);
        cpu_wdata = val;
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr    = 1'b0;
        #1;
    endtask

    task automatic set_addr(input int ofs);
        cpu_addr = ADDR_W'(ofs);
        #1;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        set_addr(2); check("R8 ctrl after reset", rd_b, 8'h00);
        set_addr(0); check("R8 latch after reset", rd_b, 8'h00);
        check("R8 pd_oe after reset", {7'b0, oe_b}, 8'h01);
        check("R8 ctl pins after reset", {4'b0, sli_b, ini_b, afd_b, stb_b}, 8'h00);
    endtask

    task automatic t_data_out();
        pd_in = 8'h5A;
        wr(0, 8'hC3);
        check("R9 pd_out after write", out_b, 8'hC3);
        settle();
        set_addr(0);
        check("R3 read returns latch in drive", rd_b, 8'hC3);
        check("R2 pd_oe in drive", {7'b0, oe_b}, 8'h01);
    endtask

    task automatic t_direction();
        wr(0, 8'hF0);
        pd_in = 8'h3C;
        settle();
        wr(2, 8'h20);
        check("R2 pd_oe released", {7'b0, oe_b}, 8'h00);
        set_addr(0);
        check("R2 read peripheral byte", rd_b, 8'h3C);
        check("R4 legacy AND readback", rd_l, 8'h30);
        check("R4 legacy still drives", {7'b0, oe_l}, 8'h01);
        check("R2 latch still on pd_out", out_b, 8'hF0);
        wr(2, 8'h00);
        check("R2 pd_oe reclaimed", {7'b0, oe_b}, 8'h01);
        set_addr(0);
        check("R3 read latch after reclaim", rd_b, 8'hF0);
        check("R4 legacy AND in drive", rd_l, 8'h30);
    endtask

    task automatic t_status();
        pin_busy = 1'b1; pin_ack = 1'b0; pin_select = 1'b1; pin_error = 1'b0;
        settle();
        set_addr(1);
        check("R5 status busy-high pattern", rd_b, 8'h10);
        pin_busy = 1'b0; pin_ack = 1'b1; pin_select = 1'b0; pin_error = 1'b1;
        settle();
        set_addr(1);
        check("R5 status busy-low pattern", rd_b, 8'hC8);
    endtask

    task automatic t_control();
        wr(2, 8'hD5);
        check("R6 pins for D5", {4'b0, sli_b, ini_b, afd_b, stb_b}, 8'h05);
        set_addr(2);
        check("R6 ctrl readback D5", rd_b, 8'hD5);
        check("R6 drive kept with bit5 clear", {7'b0, oe_b}, 8'h01);
        wr(2, 8'h0A);
        check("R6 pins for 0A", {4'b0, sli_b, ini_b, afd_b, stb_b}, 8'h0A);
        wr(2, 8'h00);
    endtask

    task automatic t_offsets();
        wr(0, 8'h81);
        wr(2, 8'h05);
        wr(3, 8'h77);
        wr(7, 8'hFF);
        set_addr(2);
        check("R1 ctrl untouched by high offsets", rd_b, 8'h05);
        set_addr(0);
        check("R1 latch untouched by high offsets", rd_b, 8'h81);
        check("R1 pins untouched", {3'b0, oe_b, sli_b, ini_b, afd_b, stb_b}, 8'h15);
        set_addr(5);
        check("R1 high offset reads zero", rd_b, 8'h00);
        wr(2, 8'h00);
    endtask

    task automatic t_sync();
        pin_busy = 1'b0;
        settle();
        @(negedge clk);
        pin_busy = 1'b1;
        cpu_addr = ADDR_W'(1);
        @(negedge clk); #1;
        check("R7 not visible after one edge", {7'b0, rd_b[7]}, 8'h01);
        @(negedge clk); #1;
        check("R7 visible after two edges", {7'b0, rd_b[7]}, 8'h00);
        wr(2, 8'h20);
        @(negedge clk);
        pd_in = 8'hA5;
        cpu_addr = ADDR_W'(0);
        @(negedge clk); #1;
        check("R7 data not visible after one edge", rd_b, 8'h3C);
        @(negedge clk); #1;
        check("R7 data visible after two edges", rd_b, 8'hA5);
        wr(2, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_data_out();
        t_direction();
        t_status();
        t_control();
        t_offsets();
        t_sync();
        report();
    end

endmodule